// File: doc/BRIEF.md
# Four-Step Soft-Start Sequencer

This block paces the start of a synchronous buck converter. Once the controller is enabled and the supply has cleared its rising lockout threshold, it clears the protection fault latch, asks the power stage to open with a low-side pulse, and counts switching cycles. It raises a current-limit level through four equal steps, from a quarter of full scale up to full scale. During the first step it also doubles the minimum off-time and applies a positive offset for the on-time generator. When the last step ends, it reports completion so that the undervoltage and power-good monitors can be armed.

The supply condition comes in on two flags that together give hysteresis. A new start needs the flag set at the rising threshold. A running sequence stays active as long as the flag set at the lower, falling threshold holds. If either that flag or the enable drops, the sequencer goes back to idle and the drivers are released to tristate. The analog current scaling itself sits outside this block.

Top module: `softstart_seq`

## Requirements
- R1: After reset, `ilim_level` is 0 and `ss_done`, `drv_en`, `dbl_toff`, `vout_ofs`, `lowside_req` and `fault_clr` are all low.
- R2: From idle, when `enable` and `vcc_rise_ok` are both high, `drv_en` rises one clock later. `fault_clr` is high for exactly that first active cycle.
- R3: `lowside_req` rises together with `drv_en` and stays high until the first `cyc_strobe` that arrives while the sequence is active.
- R4: `ilim_level` (0 = 25 %, 1 = 50 %, 2 = 75 %, 3 = 100 % of the current limit) starts at 0. It rises by one after every STEP_CYCLES strobes and never changes in a cycle without a strobe.
- R5: `dbl_toff` and `vout_ofs` are high only while the sequence is active at level 0. They are low at levels 1 to 3 and when idle.
- R6: After NUM_STEPS × STEP_CYCLES strobes, `ss_done` goes high and `ilim_level` holds at 3. Further strobes change neither.
- R7: A low `enable` sends the block back to idle on the next clock: level 0, `ss_done`, `drv_en` and the step flags all low.
- R8: While active, a low `vcc_rise_ok` with `vcc_hold_ok` still high has no effect. A low `vcc_hold_ok` sends the block back to idle as in R7.
- R9: No start happens while `vcc_rise_ok` is low, even with `enable` and `vcc_hold_ok` high. Strobes seen while idle are not counted.
- R10: A restart after a drop begins counting from zero, so any partial step count is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_strobe | input | 1 | One-clock pulse per switching cycle |
| enable | input | 1 | Converter enable |
| vcc_rise_ok | input | 1 | Supply above the rising lockout threshold |
| vcc_hold_ok | input | 1 | Supply above the falling lockout threshold |
| ilim_level | output | LVL_W | Current-limit step, 0 = 25 % to 3 = 100 % |
| dbl_toff | output | 1 | Double the minimum off-time |
| vout_ofs | output | 1 | Apply the startup offset to the on-time generator |
| ss_done | output | 1 | Ramp complete; arms the UV and power-good monitors |
| lowside_req | output | 1 | Open switching with a low-side pulse |
| fault_clr | output | 1 | One-cycle fault-latch clear |
| drv_en | output | 1 | Sequencer active; drivers tristated when low |

## Verification
The bench builds the block with STEP_CYCLES = 6 and the default NUM_STEPS = 4. With these values, every step boundary, the final completion point and the strobes after completion can be reached in a few dozen strobes. The vector table covers the strobe counts just before and just after each boundary. The same short step makes it cheap to abort a ramp partway through, restart it, and show that a 4 + 2 strobe split does not carry over into the next level.

// File: rtl/ss_pkg.sv
`timescale 1ns/1ps
package ss_pkg;
    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_RAMP = 2'd1,
        SS_DONE = 2'd2
    } ss_state_e;
endpackage

// File: rtl/ss_step_timer.sv
`timescale 1ns/1ps
module ss_step_timer #(
    parameter int LIMIT = 110,
    localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic wrap
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == TOP) begin
                cnt_d = '0;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ss_out_map.sv
`timescale 1ns/1ps
module ss_out_map
    import ss_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  ss_state_e        state,
    input  logic [LVL_W-1:0] step,
    output logic [LVL_W-1:0] level,
    output logic             first_step,
    output logic             done,
    output logic             active
);
    always_comb begin
        active     = (state != SS_IDLE);
        done       = (state == SS_DONE);
        level      = active ? step : '0;
        first_step = (state == SS_RAMP) && (step == '0);
    end
endmodule

// File: rtl/softstart_seq.sv
`timescale 1ns/1ps
module softstart_seq
    import ss_pkg::*;
#(
    parameter int STEP_CYCLES = 110,
    parameter int NUM_STEPS   = 4,
    localparam int LVL_W      = (NUM_STEPS < 2) ? 1 : $clog2(NUM_STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_strobe,
    input  logic             enable,
    input  logic             vcc_rise_ok,
    input  logic             vcc_hold_ok,
    output logic [LVL_W-1:0] ilim_level,
    output logic             dbl_toff,
    output logic             vout_ofs,
    output logic             ss_done,
    output logic             lowside_req,
    output logic             fault_clr,
    output logic             drv_en
);
    localparam logic [LVL_W-1:0] LAST_STEP = LVL_W'(NUM_STEPS - 1);

    typedef struct packed {
        ss_state_e        state;
        logic [LVL_W-1:0] step;
        logic             lsreq;
        logic             fclr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic step_wrap;
    logic timer_clr;
    logic run_ok;
    logic start_ok;
    logic first_step;

    assign run_ok    = enable && vcc_hold_ok;
    assign start_ok  = enable && vcc_rise_ok && vcc_hold_ok;
    assign timer_clr = (seq_q.state != SS_RAMP) || !run_ok;

    ss_step_timer #(.LIMIT(STEP_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .tick  (cyc_strobe),
        .wrap  (step_wrap)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.fclr = 1'b0;
        unique case (seq_q.state)
            SS_IDLE: begin
                seq_d.step  = '0;
                seq_d.lsreq = 1'b0;
                if (start_ok) begin
                    seq_d.state = SS_RAMP;
                    seq_d.lsreq = 1'b1;
                    seq_d.fclr  = 1'b1;
                end
            end
            SS_RAMP: begin
                if (!run_ok) begin
                    seq_d.state = SS_IDLE;
                    seq_d.step  = '0;
                    seq_d.lsreq = 1'b0;
                end else if (cyc_strobe) begin
                    seq_d.lsreq = 1'b0;
                    if (step_wrap) begin
                        if (seq_q.step == LAST_STEP) seq_d.state = SS_DONE;
                        else                         seq_d.step  = seq_q.step + 1'b1;
                    end
                end
            end
            SS_DONE: begin
                seq_d.lsreq = 1'b0;
                if (!run_ok) begin
                    seq_d.state = SS_IDLE;
                    seq_d.step  = '0;
                end
            end
            default: begin
                seq_d.state = SS_IDLE;
                seq_d.step  = '0;
                seq_d.lsreq = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= SS_IDLE;
            seq_q.step  <= '0;
            seq_q.lsreq <= 1'b0;
            seq_q.fclr  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    ss_out_map #(.LVL_W(LVL_W)) u_map (
        .state      (seq_q.state),
        .step       (seq_q.step),
        .level      (ilim_level),
        .first_step (first_step),
        .done       (ss_done),
        .active     (drv_en)
    );

    assign dbl_toff    = first_step;
    assign vout_ofs    = first_step;
    assign lowside_req = seq_q.lsreq;
    assign fault_clr   = seq_q.fclr;
endmodule

// File: rtl/softstart_seq_chk.sv
`timescale 1ns/1ps
module softstart_seq_chk #(
    parameter int LVL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_strobe,
    input logic             enable,
    input logic             vcc_rise_ok,
    input logic             vcc_hold_ok,
    input logic [LVL_W-1:0] ilim_level,
    input logic             dbl_toff,
    input logic             ss_done,
    input logic             lowside_req,
    input logic             fault_clr,
    input logic             drv_en
);
    // R2: the clear pulse lasts one cycle and accompanies activation
    p_fclr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> !fault_clr);
    p_fclr_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> fault_clr);

    // R3: the low-side request holds until a strobe arrives
    p_lsreq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lowside_req && !cyc_strobe && enable && vcc_hold_ok) |=> lowside_req);

    // R4: the level moves only on a strobe, and only up by one
    p_level_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && !cyc_strobe) |=> (!drv_en || $stable(ilim_level)));
    p_level_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && $past(drv_en) && !$stable(ilim_level))
            |-> (ilim_level == $past(ilim_level) + 1'b1));

    // R5: off-time doubling never occurs beyond the first level
    p_dbl_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_toff |-> (drv_en && ilim_level == '0));

    // R6: completion implies full scale and is sticky while running
    p_done_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> (ilim_level == '1));
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && enable && vcc_hold_ok) |=> ss_done);

    // R7: a low enable returns to idle
    p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!drv_en && !ss_done && ilim_level == '0));

    // R8: falling threshold lost returns to idle
    p_hold_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_hold_ok |=> !drv_en);

    // R9: a start needs the rising threshold
    p_start_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_en && !vcc_rise_ok) |=> !drv_en);
endmodule

bind softstart_seq softstart_seq_chk #(.LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_strobe  (cyc_strobe),
    .enable      (enable),
    .vcc_rise_ok (vcc_rise_ok),
    .vcc_hold_ok (vcc_hold_ok),
    .ilim_level  (ilim_level),
    .dbl_toff    (dbl_toff),
    .ss_done     (ss_done),
    .lowside_req (lowside_req),
    .fault_clr   (fault_clr),
    .drv_en      (drv_en)
);

// File: tb/softstart_seq_tb.sv
`timescale 1ns/1ps
module softstart_seq_tb;
    localparam int STEP = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_strobe = 1'b0;
    logic       enable = 1'b0;
    logic       vcc_rise_ok = 1'b0;
    logic       vcc_hold_ok = 1'b0;
    logic [1:0] ilim_level;
    logic       dbl_toff, vout_ofs, ss_done, lowside_req, fault_clr, drv_en;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    softstart_seq #(.STEP_CYCLES(STEP), .NUM_STEPS(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .enable(enable),
        .vcc_rise_ok(vcc_rise_ok), .vcc_hold_ok(vcc_hold_ok),
        .ilim_level(ilim_level), .dbl_toff(dbl_toff), .vout_ofs(vout_ofs),
        .ss_done(ss_done), .lowside_req(lowside_req), .fault_clr(fault_clr),
        .drv_en(drv_en)
    );

    typedef struct packed {
        logic [7:0] n;
        logic [1:0] lvl;
        logic       done;
        logic       boost;
    } vec_t;

    // strobes to apply, then expected level / done / first-step flags
    localparam vec_t VECS [9] = '{
        '{8'd1,  2'd0, 1'b0, 1'b1},
        '{8'd4,  2'd0, 1'b0, 1'b1},
        '{8'd1,  2'd1, 1'b0, 1'b0},
        '{8'd5,  2'd1, 1'b0, 1'b0},
        '{8'd1,  2'd2, 1'b0, 1'b0},
        '{8'd6,  2'd3, 1'b0, 1'b0},
        '{8'd5,  2'd3, 1'b0, 1'b0},
        '{8'd1,  2'd3, 1'b1, 1'b0},
        '{8'd10, 2'd3, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_strobe = 1'b1;
            @(negedge clk);
            cyc_strobe = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic idle_check(input string req);
        chk({req, " drv_en"}, drv_en, 0);
        chk({req, " level"},  ilim_level, 0);
        chk({req, " done"},   ss_done, 0);
        chk({req, " dbl"},    dbl_toff, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        idle_check("R1");
        chk("R1 lowside_req", lowside_req, 0);
        chk("R1 fault_clr", fault_clr, 0);
        chk("R1 vout_ofs", vout_ofs, 0);

        // R9: no start without rising threshold; idle strobes ignored
        enable = 1'b1;
        vcc_hold_ok = 1'b1;
        strobes(8);
        idle_check("R9");

        // R2/R3: start
        vcc_rise_ok = 1'b1;
        @(negedge clk);
        chk("R2 drv_en", drv_en, 1);
        chk("R2 fault_clr first", fault_clr, 1);
        chk("R3 lowside_req set", lowside_req, 1);
        tick(3);
        chk("R2 fault_clr single", fault_clr, 0);
        chk("R3 lowside_req held", lowside_req, 1);
        chk("R4 no strobe level", ilim_level, 0);

        // R4/R5/R6: vector walk
        for (int v = 0; v < 9; v++) begin
            strobes(int'(VECS[v].n));
            chk("R4 level", ilim_level, int'(VECS[v].lvl));
            chk("R6 done", ss_done, int'(VECS[v].done));
            chk("R5 dbl_toff", dbl_toff, int'(VECS[v].boost));
            chk("R5 vout_ofs", vout_ofs, int'(VECS[v].boost));
            if (v == 0) chk("R3 lowside_req cleared", lowside_req, 0);
        end

        // R8: hysteresis
        vcc_rise_ok = 1'b0;
        tick(4);
        chk("R8 hold keeps drv_en", drv_en, 1);
        chk("R8 hold keeps done", ss_done, 1);
        vcc_hold_ok = 1'b0;
        @(negedge clk);
        idle_check("R8");

        // R10/R7: partial ramp, disable, restart
        vcc_hold_ok = 1'b1;
        vcc_rise_ok = 1'b1;
        tick(2);
        strobes(4);
        chk("R10 partial level", ilim_level, 0);
        enable = 1'b0;
        @(negedge clk);
        idle_check("R7");
        enable = 1'b1;
        tick(2);
        chk("R10 restart clr", fault_clr, 0);
        strobes(2);
        chk("R10 count discarded", ilim_level, 0);
        strobes(4);
        chk("R10 full step", ilim_level, 1);
        tick(20);
        chk("R4 idle clocks", ilim_level, 1);

        finish_run();
    end
endmodule